// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block holds the control and status for a data converter's self-calibration run. Software writes a start bit in a control register. The block then holds that bit high for a fixed number of clock cycles, which stand in for the analog calibration work, and clears it when the run finishes. A sticky failed flag reports whether the run was spoiled.

A run is spoiled by three things: a write to any converter register, a hardware trigger select that is active, or a stop-mode request. Any one of these ends the run at once and sets the failed flag. Starting a run also sends a one-cycle abort request to the conversion engine if a conversion is in progress. A one-cycle done pulse marks the end of every run, whether it completed or failed.

The register bus is a plain write strobe with address and data. The control register reads back through a combinational read port.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset, the sequencer is idle with busy, failed flag, done and abort all 0, and the control register reads 0.
- R2: While idle, a write to the control address with bit 7 set starts a run. From the next cycle, busy (read back in bit 7) stays 1 for exactly RUN_CYCLES cycles and then clears. The done pulse is 1 for the single cycle in which busy first reads 0, and a clean run leaves the failed flag unchanged.
- R3: A start write made while conv_active is 1 gives conv_abort = 1 for exactly one cycle, the cycle after the write. A start write with conv_active at 0 gives no abort.
- R4: A write to any address during a run ends the run. On the next cycle busy reads 0, the failed flag (bit 6) reads 1 and done pulses. This holds even when the write carries a 1 in bit 6.
- R5: hw_trig_sel at 1 during any run cycle ends the run with the same result as R4.
- R6: stop_req at 1 during any run cycle ends the run with the same result as R4.
- R7: A write with bit 7 set during a run counts as a failure under R4, and no new run starts from it.
- R8: While idle, writing 1 to bit 6 of the control address clears the failed flag on the next cycle. Writing 0 to bit 6 leaves the flag unchanged. A single write of 0xC0 clears the flag and starts a run.
- R9: Bits 31 to 8 and bits 5 to 0 of the control register read 0, and every other address reads 0.
- R10: While idle, hw_trig_sel and stop_req have no effect on busy or on the failed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for writes and reads |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| hw_trig_sel | input | 1 | Hardware trigger mode selected |
| stop_req | input | 1 | Stop-mode entry request |
| conv_active | input | 1 | A conversion is in progress |
| conv_abort | output | 1 | One-cycle abort request to the conversion engine |
| cal_busy | output | 1 | Calibration run active (mirrors bit 7) |
| cal_fail | output | 1 | Sticky calibration-failed flag (mirrors bit 6) |
| cal_done | output | 1 | One-cycle end-of-run pulse |

## Verification
Every registered result (busy, failed flag, done and abort) is due one clock edge after the write or condition that causes it. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sits exactly one rising edge after its stimulus. Run length is checked by counting falling edges while busy stays high. Done is sampled on the first edge at which busy reads 0, and once more on the following edge to confirm it lasts one cycle. Reads are combinational, so they are sampled a short delay after the address settles, with no write active.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

   localparam int unsigned BIT_START = 7;
   localparam int unsigned BIT_FAIL  = 6;
   localparam int unsigned CTRL_BITS = 8;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } cal_state_e;

   typedef struct packed {
      logic any_wr;
      logic start_req;
      logic clr_req;
   } bus_cmd_t;

endpackage

// File: rtl/adc_cal_regif.sv
module adc_cal_regif
   import adc_cal_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              busy,
   input  logic              fail,
   output bus_cmd_t          cmd,
   output logic [DATA_W-1:0] rdata
);

   logic                 ctrl_sel;
   logic [CTRL_BITS-1:0] ctrl_byte;
   logic [DATA_W-1:0]    ctrl_word;

   assign ctrl_sel = (reg_addr == CTRL_ADDR);

   always_comb begin
      cmd.any_wr    = reg_wr;
      cmd.start_req = reg_wr && ctrl_sel && reg_wdata[BIT_START];
      cmd.clr_req   = reg_wr && ctrl_sel && reg_wdata[BIT_FAIL];
   end

   always_comb begin
      ctrl_byte            = '0;
      ctrl_byte[BIT_START] = busy;
      ctrl_byte[BIT_FAIL]  = fail;
   end

   generate
      if (DATA_W == CTRL_BITS) begin : g_narrow
         assign ctrl_word = ctrl_byte;
      end else begin : g_wide
         assign ctrl_word = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_byte};
      end
   endgenerate

   assign rdata = ctrl_sel ? ctrl_word : '0;

endmodule

// File: rtl/adc_cal_timer.sv
module adc_cal_timer #(
   parameter int unsigned RUN_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic active,
   output logic expire
);

   generate
      if (RUN_CYCLES == 1) begin : g_single
         assign expire = active;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(RUN_CYCLES);
         localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RUN_CYCLES - 1);

         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= LOAD_VAL;
            end else if (active && (cnt_q != '0)) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign expire = active && (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
   import adc_cal_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bus_cmd_t cmd,
   input  logic     hw_trig_sel,
   input  logic     stop_req,
   input  logic     conv_active,
   input  logic     expire,
   output logic     load,
   output logic     busy,
   output logic     fail,
   output logic     done,
   output logic     abort
);

   cal_state_e state_q, state_d;
   logic       fail_q, fail_d;
   logic       done_q, abort_q;
   logic       launch, run_fail, run_end;

   always_comb begin
      launch   = (state_q == ST_IDLE) && cmd.start_req;
      run_fail = (state_q == ST_RUN) && (cmd.any_wr || hw_trig_sel || stop_req);
      run_end  = (state_q == ST_RUN) && expire && !run_fail;
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (launch) state_d = ST_RUN;
         ST_RUN:  if (run_fail || run_end) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      fail_d = fail_q;
      if (run_fail) begin
         fail_d = 1'b1;
      end else if ((state_q == ST_IDLE) && cmd.clr_req) begin
         fail_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fail_q  <= 1'b0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         state_q <= state_d;
         fail_q  <= fail_d;
         done_q  <= run_fail || run_end;
         abort_q <= launch && conv_active;
      end
   end

   assign load  = launch;
   assign busy  = (state_q == ST_RUN);
   assign fail  = fail_q;
   assign done  = done_q;
   assign abort = abort_q;

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
   import adc_cal_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned RUN_CYCLES = 64,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(9)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              hw_trig_sel,
   input  logic              stop_req,
   input  logic              conv_active,
   output logic              conv_abort,
   output logic              cal_busy,
   output logic              cal_fail,
   output logic              cal_done
);

   generate
      if (RUN_CYCLES < 1) begin : g_bad_run
         $error("RUN_CYCLES must be at least 1");
      end
      if (DATA_W < CTRL_BITS) begin : g_bad_data
         $error("DATA_W must hold the control byte");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   bus_cmd_t cmd;
   logic     load, expire;

   adc_cal_regif #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CTRL_ADDR(CTRL_ADDR)
   ) u_regif (
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .busy     (cal_busy),
      .fail     (cal_fail),
      .cmd      (cmd),
      .rdata    (reg_rdata)
   );

   adc_cal_timer #(
      .RUN_CYCLES(RUN_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .active(cal_busy),
      .expire(expire)
   );

   adc_cal_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .hw_trig_sel(hw_trig_sel),
      .stop_req   (stop_req),
      .conv_active(conv_active),
      .expire     (expire),
      .load       (load),
      .busy       (cal_busy),
      .fail       (cal_fail),
      .done       (cal_done),
      .abort      (conv_abort)
   );

endmodule

// File: rtl/adc_cal_sequencer_chk.sv
module adc_cal_sequencer_chk #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned RUN_CYCLES = 64,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              hw_trig_sel,
   input logic              stop_req,
   input logic              conv_active,
   input logic              conv_abort,
   input logic              cal_busy,
   input logic              cal_fail,
   input logic              cal_done
);

   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy_len <= '0;
      else if (cal_busy) busy_len <= busy_len + 1;
      else               busy_len <= '0;
   end

   AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      cal_busy |-> (busy_len < RUN_CYCLES)); // R2

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cal_busy) |-> cal_done); // R2

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done); // R2

   AST_ABORT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_busy && reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[7] && conv_active)
      |=> conv_abort); // R3

   AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_abort |=> !conv_abort); // R3

   AST_WRITE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy && reg_wr) |=> (!cal_busy && cal_fail && cal_done)); // R4

   AST_TRIG_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy && hw_trig_sel) |=> (!cal_busy && cal_fail && cal_done)); // R5

   AST_STOP_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy && stop_req) |=> (!cal_busy && cal_fail && cal_done)); // R6

   AST_FAIL_W0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_busy && cal_fail && !(reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[6]))
      |=> cal_fail); // R8

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[DATA_W-1:8] == '0) && (reg_rdata[5:0] == '0)); // R9

endmodule

bind adc_cal_sequencer adc_cal_sequencer_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .RUN_CYCLES(RUN_CYCLES),
   .CTRL_ADDR (CTRL_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .hw_trig_sel(hw_trig_sel),
   .stop_req   (stop_req),
   .conv_active(conv_active),
   .conv_abort (conv_abort),
   .cal_busy   (cal_busy),
   .cal_fail   (cal_fail),
   .cal_done   (cal_done)
);

// File: tb/adc_cal_sequencer_bench.sv
module adc_cal_sequencer_bench;

   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned RUN    = 12;
   localparam logic [ADDR_W-1:0] CTRL = 4'h9;
   localparam logic [ADDR_W-1:0] OTHER = 4'h2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              hw_trig_sel = 1'b0;
   logic              stop_req = 1'b0;
   logic              conv_active = 1'b0;
   logic              conv_abort, cal_busy, cal_fail, cal_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adc_cal_sequencer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RUN_CYCLES(RUN), .CTRL_ADDR(CTRL)
   ) u_adc_cal_sequencer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig_sel(hw_trig_sel),
      .stop_req(stop_req), .conv_active(conv_active), .conv_abort(conv_abort),
      .cal_busy(cal_busy), .cal_fail(cal_fail), .cal_done(cal_done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && cal_busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] rd;
      check("R1 busy", cal_busy, 0);
      check("R1 fail", cal_fail, 0);
      check("R1 done", cal_done, 0);
      check("R1 abort", conv_abort, 0);
      bus_read(CTRL, rd);
      check("R1 ctrl read", rd, 0);
   endtask

   task automatic t_clean_run();
      int n;
      logic [31:0] rd;
      bus_write(CTRL, 32'h80);
      check("R3 no abort when idle engine", conv_abort, 0);
      bus_read(CTRL, rd);
      check("R2 start bit reads 1", rd, 32'h80);
      n = 0;
      while (cal_busy && n < 200) begin n++; @(negedge clk); end
      check("R2 run length", n, RUN);
      check("R2 done at end", cal_done, 1);
      check("R2 fail untouched", cal_fail, 0);
      @(negedge clk);
      check("R2 done one cycle", cal_done, 0);
   endtask

   task automatic t_abort();
      conv_active = 1'b1;
      bus_write(CTRL, 32'h80);
      check("R3 abort pulse", conv_abort, 1);
      conv_active = 1'b0;
      @(negedge clk);
      check("R3 abort one cycle", conv_abort, 0);
      wait_idle();
   endtask

   task automatic t_write_fail();
      logic [31:0] rd;
      bus_write(CTRL, 32'h80);
      repeat (3) @(negedge clk);
      bus_write(OTHER, 32'h0);
      check("R4 busy cleared", cal_busy, 0);
      check("R4 fail set", cal_fail, 1);
      check("R4 done pulse", cal_done, 1);
      bus_read(CTRL, rd);
      check("R9 ctrl read after fail", rd, 32'h40);
      bus_read(OTHER, rd);
      check("R9 other address reads 0", rd, 0);
   endtask

   task automatic t_w1c();
      bus_write(CTRL, 32'h00);
      check("R8 write 0 keeps fail", cal_fail, 1);
      check("R8 write 0 no start", cal_busy, 0);
      bus_write(CTRL, 32'h40);
      check("R8 w1c clears", cal_fail, 0);
   endtask

   task automatic t_w1c_during_run();
      bus_write(CTRL, 32'h80);
      @(negedge clk);
      bus_write(CTRL, 32'h40);
      check("R4 w1c in run still fails", cal_fail, 1);
      check("R4 w1c in run ends run", cal_busy, 0);
      bus_write(CTRL, 32'h40);
   endtask

   task automatic t_trig_fail();
      bus_write(CTRL, 32'h80);
      hw_trig_sel = 1'b1;
      @(negedge clk);
      hw_trig_sel = 1'b0;
      check("R5 busy cleared", cal_busy, 0);
      check("R5 fail set", cal_fail, 1);
      check("R5 done pulse", cal_done, 1);
      bus_write(CTRL, 32'h40);
   endtask

   task automatic t_stop_fail();
      bus_write(CTRL, 32'h80);
      repeat (5) @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      check("R6 busy cleared", cal_busy, 0);
      check("R6 fail set", cal_fail, 1);
      check("R6 done pulse", cal_done, 1);
   endtask

   task automatic t_combined_start_clear();
      bus_write(CTRL, 32'hC0);
      check("R8 0xC0 clears fail", cal_fail, 0);
      check("R8 0xC0 starts run", cal_busy, 1);
   endtask

   task automatic t_restart_in_run();
      @(negedge clk);
      bus_write(CTRL, 32'h80);
      check("R7 restart fails", cal_fail, 1);
      check("R7 restart ends run", cal_busy, 0);
      repeat (3) @(negedge clk);
      check("R7 no new run", cal_busy, 0);
      bus_write(CTRL, 32'h40);
   endtask

   task automatic t_idle_ignore();
      hw_trig_sel = 1'b1; stop_req = 1'b1;
      repeat (4) @(negedge clk);
      check("R10 idle busy", cal_busy, 0);
      check("R10 idle fail", cal_fail, 0);
      hw_trig_sel = 1'b0; stop_req = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_clean_run();
      t_abort();
      t_write_fail();
      t_w1c();
      t_w1c_during_run();
      t_trig_fail();
      t_stop_fail();
      t_combined_start_clear();
      t_restart_in_run();
      t_idle_ignore();
      t_clean_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule